// File: doc/BRIEF.md
# Time-Triggered Memory Wheel Arbiter

This block lets several hardware threads share one main memory without their timing depending on each other. A free-running wheel divides time into fixed windows and hands them to the threads in a fixed rotation. A thread may start a memory access only inside its own window, and only early enough that the access finishes before the window closes. A window whose owner has nothing to do stays idle and is never lent to another thread. As a result, the longest wait a thread can see is a constant that follows from the parameters alone.

Each thread presents a request with an address, write data and a write flag. The block captures the request into a per-thread holding register and keeps it there until the owner's window is open and enough of the window remains. The block then pulses grant for that thread, runs the access on an internal single-port word array with a fixed latency, and pulses done together with the read data.

Top module: `tt_mem_wheel`

## Requirements
- R1: After reset the wheel serves thread 0 first. Each thread owns WINDOW consecutive cycles, and ownership then passes to thread+1, wrapping from the last thread to thread 0. One rotation is N_THREADS*WINDOW cycles. The first cycle after reset release is cycle 0 of thread 0's window.
- R2: grant[t] is a one-cycle pulse. It rises only in a cycle owned by thread t whose position in the window is at most WINDOW-1-MEM_LAT, and at most one grant bit is high in any cycle.
- R3: done[t] is high for exactly one cycle, MEM_LAT cycles after the grant cycle of the same access, so it always falls inside the same window.
- R4: A request is sampled at the clock edge that ends the cycle in which req[t] is high, provided thread t has no access pending or in flight. The held request is granted in the first cycle after that edge which satisfies R2.
- R5: A request held too late in its owner's window to meet R2 waits for the owner's next window.
- R6: Windows whose owner holds no request leave the memory idle. No other thread is granted in them.
- R7: While thread t has an access pending or in flight, req[t] and its address, data and write flag are ignored. They neither change the stored memory nor create another grant.
- R8: A read (we=0) returns the word most recently written at that address on rd_data[t] while done[t] is high. A write (we=1) stores wr_data and returns the written word on rd_data[t]. rd_data[t] is zero whenever done[t] is low.
- R9: The time from the request cycle to the done cycle never exceeds N_THREADS*WINDOW - WINDOW + 2*MEM_LAT + 1 cycles. This is 90 cycles for six threads, 13-cycle windows and a 12-cycle latency.
- R10: While rst_n is low, every grant, done and rd_data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_THREADS | Per-thread access request, sampled when the thread is idle |
| we | input | N_THREADS | Per-thread write flag (1 = write) |
| addr | input | N_THREADS x ADDR_W | Per-thread word address |
| wr_data | input | N_THREADS x DATA_W | Per-thread write data |
| grant | output | N_THREADS | One-cycle pulse when the thread's access starts |
| done | output | N_THREADS | One-cycle pulse when the thread's access completes |
| rd_data | output | N_THREADS x DATA_W | Read data, valid with done |

## Verification
The bench builds the block with six threads, 13-cycle windows, 8-bit addresses, 32-bit data and a memory latency of 12. With that latency only the first cycle of a window may start an access. A request that lands on the owner's first cycle therefore misses it and waits a full rotation, which reaches the 90-cycle bound exactly. A request placed in the last cycle before the owner's window gives the shortest wait. The same settings make every grant and done cycle exactly predictable from a cycle count, so idle windows, ignored repeat requests and read-back after cross-thread writes are all checked at exact cycles.

// File: rtl/memwheel_pkg.sv
// Shared types for the time-triggered memory wheel.
// Assumes nothing beyond standard SystemVerilog.
package memwheel_pkg;

    // Life cycle of one thread's request slot.
    typedef enum logic [1:0] {
        HOLD_IDLE = 2'd0,   // nothing held, new request may be taken
        HOLD_PEND = 2'd1,   // request held, waiting for an eligible cycle
        HOLD_WAIT = 2'd2    // access started, waiting for completion
    } hold_state_e;

endpackage

// File: rtl/memwheel_wheel.sv
// Wheel counter: tracks which thread owns the current window and the cycle
// position inside that window. Assumes WINDOW >= 2 and N_THREADS >= 2.
module memwheel_wheel #(
    parameter int N_THREADS = 6,
    parameter int WINDOW    = 13,
    parameter int SLOT_W    = $clog2(N_THREADS),
    parameter int PH_W      = $clog2(WINDOW)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot,
    output logic [PH_W-1:0]   phase
);

    localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(WINDOW - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_THREADS - 1);

    // Advance the in-window position and hand the wheel on at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            slot  <= '0;
        end else if (phase == LAST_PH) begin
            phase <= '0;
            slot  <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // The last window of a rotation is followed by thread 0 at position 0.
    assert_wheel_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST_PH && slot == LAST_SLOT) |=> (phase == '0 && slot == '0));

    // Ownership never changes in the middle of a window.
    assert_slot_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST_PH) |=> $stable(slot));

endmodule

// File: rtl/memwheel_holder.sv
// Per-thread request holder: captures one request while the thread is idle
// and keeps it until its access starts and completes. Assumes grant is only
// raised while the holder reports pending.
module memwheel_holder
    import memwheel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              grant,
    input  logic              done,
    output logic              pending,
    output logic              h_we,
    output logic [ADDR_W-1:0] h_addr,
    output logic [DATA_W-1:0] h_wdata
);

    hold_state_e state;

    // Step the request life cycle and latch the payload on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= HOLD_IDLE;
            h_we    <= 1'b0;
            h_addr  <= '0;
            h_wdata <= '0;
        end else begin
            case (state)
                HOLD_IDLE: if (req) begin
                    state   <= HOLD_PEND;
                    h_we    <= we_in;
                    h_addr  <= addr_in;
                    h_wdata <= wdata_in;
                end
                HOLD_PEND: if (grant) state <= HOLD_WAIT;
                HOLD_WAIT: if (done)  state <= HOLD_IDLE;
                default:   state <= HOLD_IDLE;
            endcase
        end
    end

    // Pending means the request still waits for an eligible cycle.
    always_comb pending = (state == HOLD_PEND);

    // An idle thread's request is taken at once.
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HOLD_IDLE && req) |=> pending);

    // A busy thread's new request leaves the held payload untouched.
    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != HOLD_IDLE) |=> ($stable(h_addr) && $stable(h_wdata) && $stable(h_we)));

    // Grants from the arbiter only hit a pending request.
    assert_grant_needs_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pending);

endmodule

// File: rtl/memwheel_engine.sv
// Memory engine: a word array with a fixed access latency. One access at a
// time. Writes land at the start edge, and the result is reported MEM_LAT
// cycles after the start cycle. Assumes start is never raised while busy.
module memwheel_engine #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int MEM_LAT = 4,
    parameter int TID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TID_W-1:0]  start_tid,
    input  logic              s_we,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              busy,
    output logic              done,
    output logic [TID_W-1:0]  owner,
    output logic [DATA_W-1:0] rdq
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(MEM_LAT + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;

    // Storage update for writes at the start of the access.
    always_ff @(posedge clk) begin
        if (start && s_we) mem[s_addr] <= s_wdata;
    end

    // Latency countdown and capture of the result word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            owner <= '0;
            rdq   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= CNT_W'(MEM_LAT - 1);
            owner <= start_tid;
            rdq   <= s_we ? s_wdata : mem[s_addr];
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Completion is the last counted cycle of the access.
    always_comb done = busy && (cnt == '0);

    // The engine never accepts a second access while one is running.
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // Completion lasts one cycle.
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/tt_mem_wheel.sv
// Top: time-triggered arbiter for one shared memory. The wheel selects the
// owning thread; the owner's held request starts only when enough of its
// window remains for the fixed latency, so every access ends in its window.
// Assumes 1 <= MEM_LAT <= WINDOW-1.
module tt_mem_wheel
    import memwheel_pkg::*;
#(
    parameter int N_THREADS = 6,
    parameter int WINDOW    = 13,
    parameter int MEM_LAT   = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [N_THREADS-1:0]               req,
    input  logic [N_THREADS-1:0]               we,
    input  logic [N_THREADS-1:0][ADDR_W-1:0]   addr,
    input  logic [N_THREADS-1:0][DATA_W-1:0]   wr_data,
    output logic [N_THREADS-1:0]               grant,
    output logic [N_THREADS-1:0]               done,
    output logic [N_THREADS-1:0][DATA_W-1:0]   rd_data
);

    localparam int SLOT_W = $clog2(N_THREADS);
    localparam int PH_W   = $clog2(WINDOW);
    localparam logic [PH_W-1:0] LAST_START = PH_W'(WINDOW - 1 - MEM_LAT);

    logic [SLOT_W-1:0] slot;
    logic [PH_W-1:0]   phase;
    logic              eng_busy, eng_done, start;
    logic [SLOT_W-1:0] eng_owner;
    logic [DATA_W-1:0] eng_rdq;
    logic              sel_we;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              pend    [N_THREADS];
    logic              h_we    [N_THREADS];
    logic [ADDR_W-1:0] h_addr  [N_THREADS];
    logic [DATA_W-1:0] h_wdata [N_THREADS];

    memwheel_wheel #(
        .N_THREADS(N_THREADS), .WINDOW(WINDOW), .SLOT_W(SLOT_W), .PH_W(PH_W)
    ) u_wheel (
        .clk(clk), .rst_n(rst_n), .slot(slot), .phase(phase)
    );

    for (genvar t = 0; t < N_THREADS; t++) begin : g_thread
        memwheel_holder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
            .clk(clk), .rst_n(rst_n),
            .req(req[t]), .we_in(we[t]), .addr_in(addr[t]), .wdata_in(wr_data[t]),
            .grant(grant[t]), .done(done[t]),
            .pending(pend[t]), .h_we(h_we[t]), .h_addr(h_addr[t]), .h_wdata(h_wdata[t])
        );

        // Start only for the window owner, early enough to finish in-window.
        assign grant[t] = pend[t] && (slot == SLOT_W'(t))
                          && (phase <= LAST_START) && !eng_busy;

        // Completion and its data go to the thread that started the access.
        assign done[t]    = eng_done && (eng_owner == SLOT_W'(t));
        assign rd_data[t] = done[t] ? eng_rdq : '0;
    end

    assign start = |grant;

    // Route the window owner's held payload to the engine.
    always_comb begin
        sel_we    = 1'b0;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int t = 0; t < N_THREADS; t++) begin
            if (slot == SLOT_W'(t)) begin
                sel_we    = h_we[t];
                sel_addr  = h_addr[t];
                sel_wdata = h_wdata[t];
            end
        end
    end

    memwheel_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT), .TID_W(SLOT_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .start_tid(slot),
        .s_we(sel_we), .s_addr(sel_addr), .s_wdata(sel_wdata),
        .busy(eng_busy), .done(eng_done), .owner(eng_owner), .rdq(eng_rdq)
    );

    // Never more than one thread starts in a cycle.
    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // Starts only happen early enough in the window.
    assert_grant_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase <= LAST_START));

    // Every access has finished by the time a new window begins.
    assert_idle_at_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0) |-> !eng_busy);

    // At most one completion per cycle.
    assert_one_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

endmodule

// File: tb/tb_tt_mem_wheel.sv
module tb_tt_mem_wheel;

    localparam int N    = 6;
    localparam int WIN  = 13;
    localparam int LAT  = 12;
    localparam int AW   = 8;
    localparam int DW   = 32;
    localparam int ROT  = N * WIN;
    localparam int LAST = WIN - 1 - LAT;
    localparam int BOUND = ROT - WIN + 2 * LAT + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         req = '0;
    logic [N-1:0]         we = '0;
    logic [N-1:0][AW-1:0] addr = '0;
    logic [N-1:0][DW-1:0] wr_data = '0;
    logic [N-1:0]         grant;
    logic [N-1:0]         done;
    logic [N-1:0][DW-1:0] rd_data;

    tt_mem_wheel #(
        .N_THREADS(N), .WINDOW(WIN), .MEM_LAT(LAT), .ADDR_W(AW), .DATA_W(DW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wr_data(wr_data), .grant(grant), .done(done), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          r;
        int          g;
        int          d;
        logic [DW-1:0] data;
    } item_t;

    item_t         sb [N][$];
    logic [DW-1:0] model [1 << AW];
    int            cyc = 0;
    int            total = 0;
    int            bad = 0;

    // Cycle index since reset release; matches the wheel position (R1).
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endfunction

    function automatic int next_grant(int t, int from);
        int g = from;
        while (!(((g / WIN) % N) == t && (g % WIN) <= LAST)) g++;
        return g;
    endfunction

    // Driver: present a request at the current negedge and push its expectation.
    task automatic post(int t, logic [AW-1:0] a, logic [DW-1:0] d, bit w);
        item_t it;
        req[t] = 1'b1; we[t] = w; addr[t] = a; wr_data[t] = d;
        it.r = cyc;
        it.g = next_grant(t, cyc + 1);
        it.d = it.g + LAT;
        it.data = w ? d : model[a];
        if (w) model[a] = d;
        sb[t].push_back(it);
    endtask

    task automatic drop();
        @(negedge clk);
        req = '0;
    endtask

    function automatic bit all_empty();
        for (int t = 0; t < N; t++) if (sb[t].size() != 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic wait_idle();
        do @(negedge clk); while (!all_empty());
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_mod(int m);
        do @(negedge clk); while ((cyc % ROT) != m);
    endtask

    // Monitor: pop expectations as grants and completions appear.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int t = 0; t < N; t++) begin
                if (grant[t]) begin
                    if (sb[t].size() == 0) begin
                        chk(1'b0, "R6", "grant with no request", cyc, -1);
                    end else begin
                        chk(cyc == sb[t][0].g, "R4", "grant cycle", cyc, sb[t][0].g);
                        chk(((cyc / WIN) % N) == t && (cyc % WIN) <= LAST,
                            "R2", "grant outside owner window (R1)", cyc % ROT, t * WIN);
                    end
                end
                if (done[t]) begin
                    if (sb[t].size() == 0) begin
                        chk(1'b0, "R3", "done with no access", cyc, -1);
                    end else begin
                        chk(cyc == sb[t][0].d, "R3", "done cycle", cyc, sb[t][0].d);
                        chk(rd_data[t] == sb[t][0].data, "R8", "read data",
                            rd_data[t], sb[t][0].data);
                        chk(cyc - sb[t][0].r <= BOUND, "R9", "request to done",
                            cyc - sb[t][0].r, BOUND);
                        void'(sb[t].pop_front());
                    end
                end else begin
                    if (rd_data[t] != '0)
                        chk(1'b0, "R8", "rd_data without done", rd_data[t], 0);
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: outputs stay quiet during reset.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(grant == '0 && done == '0 && rd_data == '0, "R10", "outputs in reset",
                {grant, done}, 0);
        end
        rst_n = 1'b1;

        // R1, R5: all threads write at cycle 0; thread 0 misses its start slot.
        for (int t = 0; t < N; t++) post(t, AW'(16 + t), DW'(32'hA000 + t), 1'b1);
        drop();
        wait_idle();

        // R8: each thread reads a word written by its neighbour.
        @(negedge clk);
        for (int t = 0; t < N; t++) post(t, AW'(16 + (t + 1) % N), '0, 1'b0);
        drop();
        wait_idle();

        // R5, R9: request on the owner's first cycle waits a full rotation (90).
        wait_mod(3 * WIN);
        post(3, AW'(19), '0, 1'b0);
        drop();
        wait_idle();

        // R4: request in the cycle just before the owner's window: shortest wait.
        wait_mod(4 * WIN - 1);
        post(4, AW'(18), '0, 1'b0);
        drop();
        wait_idle();

        // R7: a second request while busy must be ignored (no write, no grant).
        @(negedge clk);
        post(5, AW'(20), '0, 1'b0);
        @(negedge clk);
        req[5] = 1'b1; we[5] = 1'b1; addr[5] = AW'(20); wr_data[5] = 32'hDEAD_BEEF;
        drop();
        wait_idle();
        @(negedge clk);
        post(2, AW'(20), '0, 1'b0);   // R7: must still see the old word
        drop();
        wait_idle();

        // R6: thread 1 requests inside thread 2's window; the others stay idle.
        wait_mod(2 * WIN + 3);
        post(1, AW'(17), DW'(32'h5151_0001), 1'b1);
        drop();
        wait_idle();
        @(negedge clk);
        post(0, AW'(17), '0, 1'b0);
        drop();
        wait_idle();

        // R6: a full rotation with no requests yields no grants (monitor flags any).
        repeat (ROT) @(negedge clk);
        chk(all_empty(), "R6", "queues drained", 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule